// File: doc/BRIEF.md
# Fault-Injectable Level-Sensitive Storage Cell

This block is a behavioural model of a level-sensitive D storage cell with true and complement outputs. A mode-select input can switch it into one of several functional fault behaviours, so that test sequences can be tried against the cell to see which faults they expose. The cell is modelled in synchronous logic on a fast system clock `clk`. The cell's own clock `cell_clk` and data `cell_d` are sampled as ordinary inputs on each `clk` edge.

Two monitors watch the cell. The first compares the true and complement outputs with an XNOR and keeps a sticky error flag whenever they are equal. The second flags any change of `cell_d` while `cell_clk` stays high, because data may only change while the cell is holding.

The mode codes are: 0 fault-free, 1 output stuck at 0, 2 output stuck at 1, 3 data feed-through, 4 cannot hold a 1, 5 cannot hold a 0, 6 complement output tied to the true output, and 7 reserved (acts as 0).

Top module: `fault_latch_model`

## Requirements
- R1: With `fault_sel` = 0, a clock edge that samples `cell_clk` = 1 makes `q` equal the sampled `cell_d` after that edge. A clock edge that samples `cell_clk` = 0 leaves the stored bit unchanged, and `q` shows that bit after the edge.
- R2: For every code except 6, `qn` is the inverse of `q` on every cycle.
- R3: With code 1, `q` is 0 after each edge, and with code 2, `q` is 1, whatever `cell_clk` and `cell_d` are. While either code is selected, the stored bit keeps following the R1 capture rule, so selecting code 0 again shows what was captured.
- R4: With code 3, `q` equals the `cell_d` sampled on the previous edge, in both phases of `cell_clk`. The stored bit follows the R1 capture rule.
- R5: With code 4, the cell captures as in R1 while `cell_clk` = 1. On any edge that samples `cell_clk` = 0, the stored bit and `q` become 0.
- R6: With code 5, the cell captures as in R1 while `cell_clk` = 1. On any edge that samples `cell_clk` = 0, the stored bit and `q` become 1.
- R7: With code 6, `q` behaves as in R1, and `qn` equals `q`.
- R8: `comp_err` is set on the edge after one at which the registered `q` and `qn` are equal. It then stays set.
- R9: `clr_err` = 1 clears `comp_err` on the next edge, unless `q` equals `qn` in that same cycle. In that case setting wins.
- R10: `phase_viol` is a one-cycle pulse on the edge after a cycle in which `cell_clk` is 1 on both the current and the previous sample and `cell_d` differs from its previous sample. Otherwise it is 0.
- R11: While `rst` is high on an edge, the stored bit becomes 0, `q` becomes 0, `qn` becomes 1, and both flags become 0.
- R12: Code 7 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cell_clk | input | 1 | Sampled clock of the modelled cell; 1 means transparent |
| cell_d | input | 1 | Sampled data input of the modelled cell |
| fault_sel | input | 3 | Fault behaviour code 0..7 |
| clr_err | input | 1 | Clears the sticky complementarity error |
| q | output | 1 | True output of the cell, registered |
| qn | output | 1 | Complement output of the cell, registered |
| comp_err | output | 1 | Sticky flag: `q` and `qn` were seen equal |
| phase_viol | output | 1 | Pulse: data changed during the transparent phase |

## Verification
The stored bit is hard to observe while a stuck or feed-through code hides it. The only way to see it from the ports is to capture a value under such a code, drop `cell_clk`, and then return to code 0 during the hold phase, so the held bit appears on `q`. The bench builds that sequence in both directions. It also switches into the cannot-hold codes partway through a hold phase, rather than only at a falling edge. Clear-versus-set priority is reached by asserting `clr_err` in a cycle where code 6 keeps `q` and `qn` equal, and again just after the mode returns to 0.

// File: rtl/flm_pkg.sv
package flm_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    FM_NONE  = 3'd0,
    FM_SA0   = 3'd1,
    FM_SA1   = 3'd2,
    FM_FEED  = 3'd3,
    FM_LOSE1 = 3'd4,
    FM_LOSE0 = 3'd5,
    FM_TWIN  = 3'd6,
    FM_RSVD  = 3'd7
  } fmode_e;
endpackage

// File: rtl/flm_sampler.sv
module flm_sampler (
  input  logic clk,
  input  logic cell_clk,
  input  logic cell_d,
  output logic prev_clk,
  output logic prev_d
);
  // previous samples, captured also during reset so they always hold the last cycle
  always_ff @(posedge clk) begin
    prev_clk <= cell_clk;
    prev_d   <= cell_d;
  end
endmodule

// File: rtl/flm_cell.sv
module flm_cell
  import flm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              cell_clk,
  input  logic              cell_d,
  output logic              q,
  output logic              qn
);
  fmode_e fm;
  logic   held;
  logic   held_nxt;
  logic   q_nxt;
  logic   qn_nxt;

  assign fm = fmode_e'(mode);

  // storage rule: capture while transparent, mode-dependent corruption while holding
  always_comb begin
    if (cell_clk) begin
      held_nxt = cell_d;
    end else begin
      case (fm)
        FM_LOSE1: held_nxt = 1'b0;
        FM_LOSE0: held_nxt = 1'b1;
        default:  held_nxt = held;
      endcase
    end
  end

  always_comb begin
    case (fm)
      FM_SA0:  q_nxt = 1'b0;
      FM_SA1:  q_nxt = 1'b1;
      FM_FEED: q_nxt = cell_d;
      default: q_nxt = held_nxt;
    endcase
    qn_nxt = (fm == FM_TWIN) ? q_nxt : ~q_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      q    <= 1'b0;
      qn   <= 1'b1;
    end else begin
      held <= held_nxt;
      q    <= q_nxt;
      qn   <= qn_nxt;
    end
  end
endmodule

// File: rtl/flm_comp_mon.sv
module flm_comp_mon (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic q,
  input  logic qn,
  output logic err
);
  logic same;

  assign same = q ~^ qn;

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (err & ~clr) | same;
  end
endmodule

// File: rtl/flm_phase_mon.sv
module flm_phase_mon (
  input  logic clk,
  input  logic rst,
  input  logic cell_clk,
  input  logic cell_d,
  input  logic prev_clk,
  input  logic prev_d,
  output logic viol
);
  logic d_moved;

  assign d_moved = cell_clk & prev_clk & (cell_d ^ prev_d);

  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else     viol <= d_moved;
  end
endmodule

// File: rtl/fault_latch_model.sv
module fault_latch_model
  import flm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_clk,
  input  logic              cell_d,
  input  logic [MODE_W-1:0] fault_sel,
  input  logic              clr_err,
  output logic              q,
  output logic              qn,
  output logic              comp_err,
  output logic              phase_viol
);
  logic prev_clk;
  logic prev_d;

  flm_sampler u_smp (
    .clk      (clk),
    .cell_clk (cell_clk),
    .cell_d   (cell_d),
    .prev_clk (prev_clk),
    .prev_d   (prev_d)
  );

  flm_cell u_cell (
    .clk      (clk),
    .rst      (rst),
    .mode     (fault_sel),
    .cell_clk (cell_clk),
    .cell_d   (cell_d),
    .q        (q),
    .qn       (qn)
  );

  flm_comp_mon u_cmp (
    .clk (clk),
    .rst (rst),
    .clr (clr_err),
    .q   (q),
    .qn  (qn),
    .err (comp_err)
  );

  flm_phase_mon u_ph (
    .clk      (clk),
    .rst      (rst),
    .cell_clk (cell_clk),
    .cell_d   (cell_d),
    .prev_clk (prev_clk),
    .prev_d   (prev_d),
    .viol     (phase_viol)
  );
endmodule

// File: rtl/fault_latch_model_chk.sv
module fault_latch_model_chk (
  input logic       clk,
  input logic       rst,
  input logic       cell_clk,
  input logic       cell_d,
  input logic [2:0] fault_sel,
  input logic       clr_err,
  input logic       q,
  input logic       qn,
  input logic       comp_err,
  input logic       phase_viol
);
  // R1
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd0 && cell_clk) |=> (q == $past(cell_d)));
  // R12
  rsvd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd7 && cell_clk) |=> (q == $past(cell_d)));
  // R2
  compl_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel != 3'd6) |=> (q != qn));
  // R3
  sa0_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd1) |=> !q);
  // R3
  sa1_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd2) |=> q);
  // R4
  feed_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd3) |=> (q == $past(cell_d)));
  // R5
  lose1_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd4 && !cell_clk) |=> !q);
  // R6
  lose0_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd5 && !cell_clk) |=> q);
  // R7
  twin_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == 3'd6) |=> (q == qn));
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (q == qn) |=> comp_err);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (comp_err && !clr_err) |=> comp_err);
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_err && q != qn) |=> !comp_err);
  // R10
  viol_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_clk && $past(cell_clk) && cell_d != $past(cell_d)) |=> phase_viol);
  // R10
  viol_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cell_clk || cell_d == $past(cell_d)) |=> !phase_viol);
  // R11
  rst_chk: assert property (@(posedge clk)
    rst |=> (!q && qn && !comp_err && !phase_viol));
endmodule

bind fault_latch_model fault_latch_model_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cell_clk   (cell_clk),
  .cell_d     (cell_d),
  .fault_sel  (fault_sel),
  .clr_err    (clr_err),
  .q          (q),
  .qn         (qn),
  .comp_err   (comp_err),
  .phase_viol (phase_viol)
);

// File: tb/fault_latch_model_test.sv
module fault_latch_model_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cell_clk = 1'b0;
  logic       cell_d = 1'b0;
  logic [2:0] fault_sel = 3'd0;
  logic       clr_err = 1'b0;
  logic       q, qn, comp_err, phase_viol;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  int m_held = 0, m_q = 0, m_qn = 1, m_err = 0, m_viol = 0;
  int p_clk = 0, p_d = 0;
  int m_mode_prev = 0;
  bit m_valid = 0;

  always #2.5 clk = ~clk;

  fault_latch_model uut (
    .clk(clk), .rst(rst), .cell_clk(cell_clk), .cell_d(cell_d),
    .fault_sel(fault_sel), .clr_err(clr_err),
    .q(q), .qn(qn), .comp_err(comp_err), .phase_viol(phase_viol)
  );

  always @(posedge clk) begin
    int m, h, nq, nqn, ne, nv;
    m = int'(fault_sel);
    if (rst) begin
      h = 0; nq = 0; nqn = 1; ne = 0; nv = 0;
    end else begin
      if (cell_clk) h = int'(cell_d);
      else if (m == 4) h = 0;
      else if (m == 5) h = 1;
      else h = m_held;
      if (m == 1) nq = 0;
      else if (m == 2) nq = 1;
      else if (m == 3) nq = int'(cell_d);
      else nq = h;
      nqn = (m == 6) ? nq : 1 - nq;
      ne = ((m_err == 1 && !clr_err) || m_q == m_qn) ? 1 : 0;
      nv = (cell_clk && p_clk == 1 && int'(cell_d) != p_d) ? 1 : 0;
    end
    p_clk = int'(cell_clk);
    p_d = int'(cell_d);
    m_held = h; m_q = nq; m_qn = nqn; m_err = ne; m_viol = nv;
    m_mode_prev = m;
    m_valid = 1;
  end

  function automatic string q_tag(int md, bit was_rst);
    if (was_rst) return "R11";
    case (md)
      0: return "R1";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  bit rst_seen;
  always @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(q_tag(m_mode_prev, rst_seen), "q", int'(q), m_q);
      chk(rst_seen ? "R11" : (m_mode_prev == 6 ? "R7" : "R2"), "qn", int'(qn), m_qn);
      chk(rst_seen ? "R11" : "R8", "comp_err", int'(comp_err), m_err);
      chk(rst_seen ? "R11" : "R10", "phase_viol", int'(phase_viol), m_viol);
    end
  end

  task automatic step(bit c, bit d, int n = 1);
    cell_clk = c; cell_d = d;
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic cyc_store(bit d);
    step(1'b0, d);
    step(1'b1, d, 2);
    step(1'b0, d, 2);
  endtask

  initial begin
    #5000000;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state checked by the monitor while rst high
    rst = 1'b0;
    // R1 fault-free capture and hold
    fault_sel = 3'd0;
    cyc_store(1'b1);
    cyc_store(1'b0);
    cyc_store(1'b1);
    step(1'b0, 1'b0, 3);
    // R3 stuck codes; stored bit tracks hidden capture
    fault_sel = 3'd1;
    cyc_store(1'b1);
    fault_sel = 3'd0;
    step(1'b0, 1'b0, 2);
    fault_sel = 3'd2;
    cyc_store(1'b0);
    fault_sel = 3'd0;
    step(1'b0, 1'b1, 2);
    // R4 feed-through in both phases
    fault_sel = 3'd3;
    step(1'b0, 1'b1, 2);
    step(1'b0, 1'b0, 2);
    step(1'b1, 1'b1, 2);
    step(1'b0, 1'b0, 1);
    fault_sel = 3'd0;
    step(1'b0, 1'b0, 2);
    // R5 cannot hold 1: at falling phase and switched mid-hold
    fault_sel = 3'd4;
    cyc_store(1'b1);
    cyc_store(1'b0);
    fault_sel = 3'd0;
    cyc_store(1'b1);
    fault_sel = 3'd4;
    step(1'b0, 1'b1, 2);
    // R6 cannot hold 0
    fault_sel = 3'd5;
    cyc_store(1'b0);
    cyc_store(1'b1);
    fault_sel = 3'd0;
    cyc_store(1'b0);
    fault_sel = 3'd5;
    step(1'b0, 1'b0, 2);
    // R7, R8 tied complement sets the sticky flag
    fault_sel = 3'd6;
    cyc_store(1'b1);
    cyc_store(1'b0);
    // R9 clear while still equal: set wins
    clr_err = 1'b1;
    step(1'b0, 1'b0, 1);
    fault_sel = 3'd0;
    step(1'b0, 1'b0, 1);
    step(1'b0, 1'b0, 1);
    clr_err = 1'b0;
    step(1'b0, 1'b0, 3);
    // R8 flag stays low in fault-free operation
    cyc_store(1'b1);
    // R10 data moving while transparent
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0, 2);
    // R12 reserved code
    fault_sel = 3'd7;
    cyc_store(1'b1);
    cyc_store(1'b0);
    // R11 reset mid-run with a 1 stored and flag set
    fault_sel = 3'd6;
    cyc_store(1'b1);
    fault_sel = 3'd0;
    rst = 1'b1;
    step(1'b0, 1'b0, 2);
    rst = 1'b0;
    step(1'b0, 1'b0, 3);
    cyc_store(1'b1);
    @(negedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule